// File: doc/BRIEF.md
# Load Hit Speculation Gate

This block sits beside the integer issue queue. It decides, for each integer load, whether the instructions that consume the load's result may be woken speculatively. Waking them speculatively means assuming a data-cache hit, so they issue at the earliest slot the hit latency allows. The alternative is to hold them until the real hit/miss outcome arrives. The decision comes from a table of 2-bit saturating confidence counters indexed by the load's instruction address. Each load's resolved outcome trains the table.

A load enters in cycle t with its address and a consumer tag. In cycle t+3 the block wakes the tag speculatively when the counter allowed it. In cycle t+5 the cache reports hit or miss for the same load address. If a speculated load misses, the block raises a squash with the load's tag, so that the reissue logic can replay the consumer and everything issued after it. If the load was not speculated and it hits, the block wakes the tag at t+5. A non-speculated miss produces nothing here, because the fill path wakes it later. The cache and the replay machinery lie outside this block.

Top module: `ldspec_gate`

## Requirements
- R1: After reset every output is low and every confidence counter holds 3, so the first encounter of any load is speculated.
- R2: The table entry is selected by address bits [7:2]. Bits [1:0] and bits above 7 have no effect on the entry used, so addresses that differ only there share one counter.
- R3: A load is speculated when its counter, read in the issue cycle, is 2 or 3. A training update in that same cycle is not visible to that read.
- R4: A speculated load issued in cycle t raises `early_wake_vld` with its tag in cycle t+3, and in no other cycle.
- R5: A load that was not speculated and resolves as a hit in cycle t+5 raises `late_wake_vld` with its tag in cycle t+5. It gives no early wake.
- R6: A speculated load that resolves as a miss in cycle t+5 raises `squash_vld` with its tag in cycle t+5. A speculated hit raises nothing at t+5.
- R7: Every cycle with `res_vld` high trains the counter at the entry of `res_pc`: a hit adds one up to 3, and a miss subtracts one down to 0. This happens whether or not a tracked load is resolving, and such an orphan resolve raises no squash.
- R8: Loads may issue in back-to-back cycles. Up to five are in flight, each keeping its own tag, prediction and timing.
- R9: A load that was not speculated and misses raises neither a wake nor a squash.
- R10: Reset drops every load in flight, so none of them produces a later wake or squash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_vld | input | 1 | An integer load issues this cycle |
| iss_pc | input | 32 | Instruction address of the issuing load |
| iss_tag | input | 6 | Wakeup tag of the load's destination |
| res_vld | input | 1 | Cache outcome for the load issued five cycles ago |
| res_pc | input | 32 | Instruction address of the resolving load |
| res_hit | input | 1 | 1 = hit, 0 = miss |
| early_wake_vld | output | 1 | Speculative wake of consumers (t+3) |
| early_wake_tag | output | 6 | Tag being woken speculatively |
| late_wake_vld | output | 1 | Conservative wake after a confirmed hit (t+5) |
| late_wake_tag | output | 6 | Tag being woken conservatively |
| squash_vld | output | 1 | Speculated load missed: replay consumers |
| squash_tag | output | 6 | Tag of the load that missed |

## Verification
The bench first runs single loads spaced six cycles apart, so that each training update lands before the next encounter. This walks one counter down through 2, 1 and 0 and back up to 3. It separates the threshold at 2, saturation at both ends and aliased addresses from a neighbouring entry that is left untouched. A back-to-back burst to one entry then shows that an update and a read of the same entry in one cycle return the old value, and that the tags stay in order through a full pipeline. The bench also sends orphan resolves that train without squashing, and applies a reset while a load is in flight. This reset test tells a cleared pipeline and restored counters apart from stale state.

// File: rtl/ldspec_pkg.sv
package ldspec_pkg;

  typedef logic [1:0] sat2_t;

  localparam sat2_t SAT2_MAX = 2'd3;
  localparam sat2_t SAT2_MIN = 2'd0;

  typedef enum logic [1:0] {
    OUT_NONE      = 2'd0,
    OUT_SQUASH    = 2'd1,
    OUT_LATE_WAKE = 2'd2
  } outcome_e;

  // Saturating step of a 2-bit confidence counter.
  function automatic sat2_t sat2_step(input sat2_t cur, input logic hit);
    if (hit)
      return (cur == SAT2_MAX) ? cur : sat2_t'(cur + 2'd1);
    else
      return (cur == SAT2_MIN) ? cur : sat2_t'(cur - 2'd1);
  endfunction

  // Upper half of the counter range permits speculation.
  function automatic logic sat2_allows(input sat2_t cur);
    return cur[1];
  endfunction

  // What happens when a tracked load meets its cache outcome.
  function automatic outcome_e judge(input logic ld_vld, input logic spec,
                                     input logic res_vld, input logic hit);
    if (!(ld_vld && res_vld)) return OUT_NONE;
    if (spec)                 return hit ? OUT_NONE : OUT_SQUASH;
    return hit ? OUT_LATE_WAKE : OUT_NONE;
  endfunction

endpackage

// File: rtl/ldspec_table.sv
module ldspec_table
  import ldspec_pkg::*;
#(
  parameter int    IDX_W    = 6,
  parameter sat2_t CTR_INIT = 2'd3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_spec,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_hit
);

  localparam int ENTRIES = 1 << IDX_W;

  sat2_t ctr_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic hit_here;
    assign hit_here = wr_en && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ctr_q[e] <= CTR_INIT;
      else if (hit_here) ctr_q[e] <= sat2_step(ctr_q[e], wr_hit);
    end
  end

  // Read sees the registered value: a same-cycle update is not bypassed.
  assign rd_spec = sat2_allows(ctr_q[rd_idx]);

endmodule

// File: rtl/ldspec_track.sv
module ldspec_track #(
  parameter int TAG_W    = 6,
  parameter int SPEC_LAT = 3,
  parameter int RSL_LAT  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic             in_spec,
  input  logic [TAG_W-1:0] in_tag,
  output logic             early_vld,
  output logic [TAG_W-1:0] early_tag,
  output logic             tail_vld,
  output logic             tail_spec,
  output logic [TAG_W-1:0] tail_tag
);

  typedef struct packed {
    logic             vld;
    logic             spec;
    logic [TAG_W-1:0] tag;
  } stage_t;

  stage_t stage_q [RSL_LAT];

  for (genvar s = 0; s < RSL_LAT; s++) begin : g_stage
    stage_t nxt;
    if (s == 0) begin : g_head
      assign nxt = '{vld: in_vld, spec: in_spec, tag: in_tag};
    end else begin : g_body
      assign nxt = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= nxt;
    end
  end

  assign early_vld = stage_q[SPEC_LAT-1].vld && stage_q[SPEC_LAT-1].spec;
  assign early_tag = stage_q[SPEC_LAT-1].tag;
  assign tail_vld  = stage_q[RSL_LAT-1].vld;
  assign tail_spec = stage_q[RSL_LAT-1].spec;
  assign tail_tag  = stage_q[RSL_LAT-1].tag;

endmodule

// File: rtl/ldspec_resolve.sv
module ldspec_resolve
  import ldspec_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             ld_vld,
  input  logic             ld_spec,
  input  logic [TAG_W-1:0] ld_tag,
  input  logic             res_vld,
  input  logic             res_hit,
  output logic             squash_vld,
  output logic [TAG_W-1:0] squash_tag,
  output logic             late_vld,
  output logic [TAG_W-1:0] late_tag
);

  outcome_e verdict;

  assign verdict    = judge(ld_vld, ld_spec, res_vld, res_hit);
  assign squash_vld = (verdict == OUT_SQUASH);
  assign late_vld   = (verdict == OUT_LATE_WAKE);
  assign squash_tag = squash_vld ? ld_tag : '0;
  assign late_tag   = late_vld   ? ld_tag : '0;

endmodule

// File: rtl/ldspec_gate.sv
module ldspec_gate
  import ldspec_pkg::*;
#(
  parameter int    PC_W     = 32,
  parameter int    TAG_W    = 6,
  parameter int    IDX_W    = 6,
  parameter int    OFS_W    = 2,
  parameter int    SPEC_LAT = 3,
  parameter int    RSL_LAT  = 5,
  parameter sat2_t CTR_INIT = 2'd3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_vld,
  input  logic [PC_W-1:0]  iss_pc,
  input  logic [TAG_W-1:0] iss_tag,
  input  logic             res_vld,
  input  logic [PC_W-1:0]  res_pc,
  input  logic             res_hit,
  output logic             early_wake_vld,
  output logic [TAG_W-1:0] early_wake_tag,
  output logic             late_wake_vld,
  output logic [TAG_W-1:0] late_wake_tag,
  output logic             squash_vld,
  output logic [TAG_W-1:0] squash_tag
);

  localparam int IDX_HI = OFS_W + IDX_W;

  function automatic logic [IDX_W-1:0] pc_index(input logic [PC_W-1:0] pc);
    return pc[OFS_W +: IDX_W];
  endfunction

  // Named internal events (observed by the bound checker).
  logic             tbl_spec;
  logic             early_raw;
  logic [TAG_W-1:0] early_tag_raw;
  logic             tail_vld;
  logic             tail_spec;
  logic [TAG_W-1:0] tail_tag;
  logic             rs_spec_vld;
  logic             unused_pc_bits;

  assign unused_pc_bits = ^{iss_pc[PC_W-1:IDX_HI], iss_pc[OFS_W-1:0],
                            res_pc[PC_W-1:IDX_HI], res_pc[OFS_W-1:0]};

  ldspec_table #(
    .IDX_W    (IDX_W),
    .CTR_INIT (CTR_INIT)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (pc_index(iss_pc)),
    .rd_spec (tbl_spec),
    .wr_en   (res_vld),
    .wr_idx  (pc_index(res_pc)),
    .wr_hit  (res_hit)
  );

  ldspec_track #(
    .TAG_W    (TAG_W),
    .SPEC_LAT (SPEC_LAT),
    .RSL_LAT  (RSL_LAT)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (iss_vld),
    .in_spec   (tbl_spec),
    .in_tag    (iss_tag),
    .early_vld (early_raw),
    .early_tag (early_tag_raw),
    .tail_vld  (tail_vld),
    .tail_spec (tail_spec),
    .tail_tag  (tail_tag)
  );

  assign rs_spec_vld    = tail_vld && tail_spec;
  assign early_wake_vld = early_raw;
  assign early_wake_tag = early_raw ? early_tag_raw : '0;

  ldspec_resolve #(
    .TAG_W (TAG_W)
  ) u_resolve (
    .ld_vld     (tail_vld),
    .ld_spec    (tail_spec),
    .ld_tag     (tail_tag),
    .res_vld    (res_vld),
    .res_hit    (res_hit),
    .squash_vld (squash_vld),
    .squash_tag (squash_tag),
    .late_vld   (late_wake_vld),
    .late_tag   (late_wake_tag)
  );

endmodule

// File: rtl/ldspec_chk.sv
module ldspec_chk #(
  parameter int TAG_W    = 6,
  parameter int SPEC_LAT = 3,
  parameter int RSL_LAT  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_vld,
  input logic [TAG_W-1:0] iss_tag,
  input logic             tbl_spec,
  input logic             res_vld,
  input logic             res_hit,
  input logic             early_wake_vld,
  input logic [TAG_W-1:0] early_wake_tag,
  input logic             late_wake_vld,
  input logic             squash_vld,
  input logic             rs_spec_vld
);

  // R4
  issue_to_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld && tbl_spec) |-> ##SPEC_LAT
      (early_wake_vld && early_wake_tag == $past(iss_tag, SPEC_LAT)));

  // R4
  early_reaches_resolve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    early_wake_vld |-> ##(RSL_LAT - SPEC_LAT) rs_spec_vld);

  // R6
  squash_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash_vld |-> (res_vld && !res_hit && rs_spec_vld));

  // R5
  late_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    late_wake_vld |-> (res_vld && res_hit && !rs_spec_vld));

  // R9
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({squash_vld, late_wake_vld}));

endmodule

bind ldspec_gate ldspec_chk #(
  .TAG_W    (TAG_W),
  .SPEC_LAT (SPEC_LAT),
  .RSL_LAT  (RSL_LAT)
) u_ldspec_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .iss_vld        (iss_vld),
  .iss_tag        (iss_tag),
  .tbl_spec       (tbl_spec),
  .res_vld        (res_vld),
  .res_hit        (res_hit),
  .early_wake_vld (early_wake_vld),
  .early_wake_tag (early_wake_tag),
  .late_wake_vld  (late_wake_vld),
  .squash_vld     (squash_vld),
  .rs_spec_vld    (rs_spec_vld)
);

// File: tb/test_ldspec_gate.sv
module test_ldspec_gate;

  localparam int SPL  = 3;
  localparam int RSL  = 5;
  localparam int NROW = 25;

  // Row: pc[39:8], tag[7:2], hit[1], expected speculation[0]
  localparam logic [39:0] ROWS [NROW] = '{
    // single loads, entry 5 (pc 0x14), aliases 0x1017 / 0x1014, entry 9 (0x24)
    {32'h0000_0014, 6'd1,  1'b0, 1'b1},  // 3->2
    {32'h0000_1017, 6'd2,  1'b0, 1'b1},  // 2->1 alias
    {32'h0000_0014, 6'd3,  1'b1, 1'b0},  // 1->2
    {32'h0000_0014, 6'd4,  1'b1, 1'b1},  // 2->3
    {32'h0000_0014, 6'd5,  1'b0, 1'b1},  // 3->2
    {32'h0000_1014, 6'd6,  1'b0, 1'b1},  // 2->1 alias
    {32'h0000_0014, 6'd7,  1'b0, 1'b0},  // 1->0
    {32'h0000_0014, 6'd8,  1'b0, 1'b0},  // 0->0
    {32'h0000_0024, 6'd9,  1'b1, 1'b1},  // neighbour untouched
    {32'h0000_0014, 6'd10, 1'b1, 1'b0},  // 0->1
    {32'h0000_0014, 6'd11, 1'b1, 1'b0},  // 1->2
    {32'h0000_0014, 6'd12, 1'b1, 1'b1},  // 2->3
    {32'h0000_0014, 6'd13, 1'b1, 1'b1},  // 3->3
    {32'h0000_0014, 6'd14, 1'b0, 1'b1},  // 3->2
    {32'h0000_0014, 6'd15, 1'b1, 1'b1},  // 2->3
    // back-to-back burst, entry 20 (pc 0x50)
    {32'h0000_0050, 6'h20, 1'b0, 1'b1},
    {32'h0000_0050, 6'h21, 1'b0, 1'b1},
    {32'h0000_0050, 6'h22, 1'b1, 1'b1},
    {32'h0000_0050, 6'h23, 1'b1, 1'b1},
    {32'h0000_0050, 6'h24, 1'b1, 1'b1},
    {32'h0000_0050, 6'h25, 1'b1, 1'b1},
    {32'h0000_0050, 6'h26, 1'b1, 1'b1},  // reads 2 in the cycle 1 is written
    {32'h0000_0050, 6'h27, 1'b1, 1'b0},
    // after two orphan misses on entry 9
    {32'h0000_0024, 6'h30, 1'b1, 1'b0},
    // after reset restores entry 9
    {32'h0000_0024, 6'h31, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_vld = 1'b0;
  logic [31:0] iss_pc = '0;
  logic [5:0]  iss_tag = '0;
  logic        res_vld = 1'b0;
  logic [31:0] res_pc = '0;
  logic        res_hit = 1'b0;
  logic        early_wake_vld;
  logic [5:0]  early_wake_tag;
  logic        late_wake_vld;
  logic [5:0]  late_wake_tag;
  logic        squash_vld;
  logic [5:0]  squash_tag;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  ldspec_gate i_ldspec_gate (
    .clk            (clk),
    .rst_n          (rst_n),
    .iss_vld        (iss_vld),
    .iss_pc         (iss_pc),
    .iss_tag        (iss_tag),
    .res_vld        (res_vld),
    .res_pc         (res_pc),
    .res_hit        (res_hit),
    .early_wake_vld (early_wake_vld),
    .early_wake_tag (early_wake_tag),
    .late_wake_vld  (late_wake_vld),
    .late_wake_tag  (late_wake_tag),
    .squash_vld     (squash_vld),
    .squash_tag     (squash_tag)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    iss_vld = 1'b0; iss_pc = '0; iss_tag = '0;
    res_vld = 1'b0; res_pc = '0; res_hit = 1'b0;
  endtask

  task automatic quiet_outputs(input string req);
    chk(req, "early_wake_vld", 32'(early_wake_vld), 32'd0);
    chk(req, "late_wake_vld",  32'(late_wake_vld),  32'd0);
    chk(req, "squash_vld",     32'(squash_vld),     32'd0);
  endtask

  // Issue rows first..first+n-1, one every sp cycles; resolve each after RSL.
  task automatic run_rows(input int first, input int n, input int sp, input string req);
    logic [39:0] row;
    logic        e_v, l_v, s_v;
    logic [5:0]  e_t, r_t;
    int          last;
    last = (n - 1) * sp + RSL;
    for (int c = 0; c <= last; c++) begin
      @(negedge clk);
      idle_inputs();
      if ((c % sp) == 0 && (c / sp) < n) begin
        row = ROWS[first + c / sp];
        iss_vld = 1'b1; iss_pc = row[39:8]; iss_tag = row[7:2];
      end
      l_v = 1'b0; s_v = 1'b0; r_t = '0;
      if (c >= RSL && ((c - RSL) % sp) == 0 && ((c - RSL) / sp) < n) begin
        row = ROWS[first + (c - RSL) / sp];
        res_vld = 1'b1; res_pc = row[39:8]; res_hit = row[1];
        l_v = !row[0] && row[1];
        s_v = row[0] && !row[1];
        r_t = row[7:2];
      end
      e_v = 1'b0; e_t = '0;
      if (c >= SPL && ((c - SPL) % sp) == 0 && ((c - SPL) / sp) < n) begin
        row = ROWS[first + (c - SPL) / sp];
        e_v = row[0]; e_t = row[7:2];
      end
      #1;
      chk({"R3 R4 ", req}, "early_wake_vld", 32'(early_wake_vld), 32'(e_v));
      if (e_v) chk({"R4 ", req}, "early_wake_tag", 32'(early_wake_tag), 32'(e_t));
      chk({"R5 R9 ", req}, "late_wake_vld", 32'(late_wake_vld), 32'(l_v));
      if (l_v) chk({"R5 ", req}, "late_wake_tag", 32'(late_wake_tag), 32'(r_t));
      chk({"R6 R9 ", req}, "squash_vld", 32'(squash_vld), 32'(s_v));
      if (s_v) chk({"R6 ", req}, "squash_tag", 32'(squash_tag), 32'(r_t));
    end
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    idle_inputs();
    repeat (3) @(negedge clk);
    #1 quiet_outputs("R1");
    @(negedge clk);
    rst_n = 1'b1;
    #1 quiet_outputs("R1");

    // R2 R7: counter walk, saturation, aliasing, neighbour isolation
    run_rows(0, 15, 6, "R2 R7");

    // R8: back-to-back burst, R3 same-cycle read sees old value
    run_rows(15, 8, 1, "R8 R3");

    // R7: orphan resolves train entry 9 (3->1) without squash
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      idle_inputs();
      res_vld = 1'b1; res_pc = 32'h24; res_hit = 1'b0;
      #1 chk("R7", "orphan squash_vld", 32'(squash_vld), 32'd0);
    end
    @(negedge clk);
    idle_inputs();
    run_rows(23, 1, 6, "R7");

    // R10: reset while a load is in flight
    @(negedge clk);
    iss_vld = 1'b1; iss_pc = 32'h24; iss_tag = 6'h3a;
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b0;
    #1 quiet_outputs("R1 R10");
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      #1 quiet_outputs("R10");
    end

    // R1: counters restored to 3 by reset
    run_rows(24, 1, 6, "R1");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule